// File: doc/BRIEF.md
# DMA Staging Buffer Fill/Drain Sequencer

This block drives the data movement of one DMA channel through its internal staging buffer. A job is started with a byte count and a configuration: the direction of the job (memory to memory, memory to peripheral, or peripheral to memory), the buffer capacity, the peripheral port width and, for memory-to-memory jobs, a destination transfer size. The sequencer then issues a series of bus transfer requests. Each request carries a size, a direction (read to fill the buffer, write to drain it) and a flag that says whether the peripheral or the memory is the target. Address generation and the bus protocol are handled elsewhere. The bus side answers every request with a one-cycle completion strobe.

The fill and the drain do not use the same granularity. The memory side always moves the whole buffer in one request. The peripheral side moves the buffer in pieces the width of the port, and no piece is larger than 32 bytes. Fills and drains strictly take turns. When fewer bytes remain than the current transfer size, the request is cut down to the bytes that remain. After the last byte has been written, a one-cycle end-of-descriptor pulse marks the end of the job.

Top module: `dma_stg_seq`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `req_valid`, `eod` and `busy` are all 0.
- R2: A `start` pulse is accepted only when `busy` is 0, `mode` is not 2'b11 and `buf_cap` is nonzero. Any other start leaves the block idle with no request.
- R3: `mode` 2'b01 (memory to peripheral): each fill is one read with `req_periph`=0 and a size of min(`buf_cap`, bytes left). The drain is a series of writes with `req_periph`=1. Each write has the piece size, limited to what the buffer still holds. The piece size is `port_size`, or 32 when `port_size` is 0 or above 32.
- R4: `mode` 2'b10 (peripheral to memory): the fill is a series of reads with `req_periph`=1, each of the piece size, limited to what is left to fill. The drain is a single write with `req_periph`=0 that empties the buffer.
- R5: `mode` 2'b00 (memory to memory): each fill is one read of min(`buf_cap`, bytes left). The drain is a series of writes of `mm_dst_size`, limited to what the buffer holds. A `mm_dst_size` of 0 or above `buf_cap` is replaced by `buf_cap`. `req_periph` is always 0.
- R6: Fill and drain alternate. A write is requested only when the fill is complete. A read that follows a write is requested only once the buffer is empty. Occupancy never exceeds `buf_cap`.
- R7: When fewer bytes remain than the transfer size, the request is cut to the remaining bytes. The sizes written over a job add up to `byte_count`, and no request has size 0.
- R8: A request keeps `req_valid`, `req_size`, `req_write` and `req_periph` unchanged until the cycle in which `xfer_done` is 1.
- R9: Occupancy and the byte count change only on `xfer_done`. Without the strobe, the sequencer does not move on.
- R10: `eod` is a one-cycle pulse. It comes in the cycle after the completion of the final write, and `busy` is 0 in that same cycle. A start with `byte_count` 0 gives `eod` one cycle later and issues no request.
- R11: The mode, capacity, port size and destination size are captured when the start is accepted. Changes to those inputs during a job have no effect.
- R12: A `start` while `busy` is 1 is ignored and the pending request is unchanged. A `start` in the `eod` cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a job (one-cycle pulse) |
| mode | input | 2 | 00 mem-to-mem, 01 mem-to-peripheral, 10 peripheral-to-mem, 11 reserved |
| buf_cap | input | 8 | Staging buffer capacity in bytes, also the memory-side transfer size |
| port_size | input | 8 | Peripheral port width in bytes |
| mm_dst_size | input | 8 | Destination write size for memory-to-memory jobs |
| byte_count | input | 16 | Bytes to move in this job |
| xfer_done | input | 1 | Bus completion strobe for the pending request |
| req_valid | output | 1 | A transfer request is pending |
| req_write | output | 1 | 1: drain (write from buffer); 0: fill (read into buffer) |
| req_periph | output | 1 | 1: the transfer targets the peripheral |
| req_size | output | 8 | Transfer size in bytes |
| eod | output | 1 | End-of-descriptor pulse |
| busy | output | 1 | A job is in progress |

## Verification
Two events can fall in the same cycle: the end-of-descriptor pulse after the final write completes, and the start of the next job. The bench raises `start` with a new configuration in exactly the cycle where `eod` is 1. It then expects the first fill request of the new job, with the new job's size and peripheral flag, one cycle later. A second collision is also provoked: a start that arrives while a request is waiting for its completion strobe. This case is judged by checking that the pending request stays unchanged and that the running job ends with its own transfer count.

// File: rtl/dma_stg_pkg.sv
package dma_stg_pkg;

    parameter int unsigned SZ_W       = 8;
    parameter int unsigned CNT_W      = 16;
    parameter int unsigned PERIPH_CAP = 32;

    localparam logic [SZ_W-1:0] PIECE_MAX = SZ_W'(PERIPH_CAP);

    typedef enum logic [1:0] {
        XM_MEM2MEM = 2'b00,
        XM_MEM2PER = 2'b01,
        XM_PER2MEM = 2'b10,
        XM_RSVD    = 2'b11
    } xfer_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_DRAIN
    } seq_state_e;

    typedef struct packed {
        xfer_mode_e      mode;
        logic [SZ_W-1:0] cap;
        logic [SZ_W-1:0] port;
        logic [SZ_W-1:0] dst;
    } stg_cfg_t;

    typedef struct packed {
        logic [SZ_W-1:0] src_size;
        logic [SZ_W-1:0] dst_size;
        logic            src_periph;
        logic            dst_periph;
    } side_plan_t;

    typedef struct packed {
        logic            write;
        logic            periph;
        logic [SZ_W-1:0] size;
    } xfer_req_t;

    function automatic logic [SZ_W-1:0] min_sz(input logic [SZ_W-1:0] a,
                                                input logic [SZ_W-1:0] b);
        return (a < b) ? a : b;
    endfunction

    function automatic logic [SZ_W-1:0] piece_size(input logic [SZ_W-1:0] port);
        return (port == '0 || port > PIECE_MAX) ? PIECE_MAX : port;
    endfunction

    function automatic logic [SZ_W-1:0] mm_dst(input logic [SZ_W-1:0] dst,
                                                input logic [SZ_W-1:0] cap);
        return (dst == '0 || dst > cap) ? cap : dst;
    endfunction

    function automatic logic [SZ_W-1:0] cap_or_rem(input logic [CNT_W-1:0] rem,
                                                    input logic [SZ_W-1:0]  cap);
        return (rem < CNT_W'(cap)) ? rem[SZ_W-1:0] : cap;
    endfunction

endpackage

// File: rtl/stg_side_plan.sv
module stg_side_plan
    import dma_stg_pkg::*;
(
    input  stg_cfg_t   cfg,
    output side_plan_t plan
);
    logic [SZ_W-1:0] piece;
    logic [SZ_W-1:0] mdst;

    assign piece = piece_size(cfg.port);
    assign mdst  = mm_dst(cfg.dst, cfg.cap);

    always_comb begin
        plan = '0;
        unique case (cfg.mode)
            XM_MEM2PER: begin
                plan.src_size   = cfg.cap;
                plan.dst_size   = piece;
                plan.src_periph = 1'b0;
                plan.dst_periph = 1'b1;
            end
            XM_PER2MEM: begin
                plan.src_size   = piece;
                plan.dst_size   = cfg.cap;
                plan.src_periph = 1'b1;
                plan.dst_periph = 1'b0;
            end
            default: begin
                plan.src_size   = cfg.cap;
                plan.dst_size   = mdst;
                plan.src_periph = 1'b0;
                plan.dst_periph = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/stg_fill_drain_fsm.sv
module stg_fill_drain_fsm
    import dma_stg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             launch,
    input  logic [CNT_W-1:0] launch_cnt,
    input  logic [SZ_W-1:0]  launch_cap,
    input  logic [SZ_W-1:0]  cap,
    input  side_plan_t       plan,
    input  logic             xfer_done,
    output logic             req_valid,
    output xfer_req_t        req,
    output logic             eod,
    output logic             busy
);
    seq_state_e       state_q;
    logic [CNT_W-1:0] rem_q;
    logic [SZ_W-1:0]  occ_q;
    logic [SZ_W-1:0]  fill_left_q;
    logic             eod_q;
    logic [SZ_W-1:0]  cur_size;
    logic [CNT_W-1:0] rem_after;

    always_comb begin
        cur_size = '0;
        if (state_q == ST_FILL)       cur_size = min_sz(plan.src_size, fill_left_q);
        else if (state_q == ST_DRAIN) cur_size = min_sz(plan.dst_size, occ_q);
    end

    assign rem_after = rem_q - CNT_W'(cur_size);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            rem_q       <= '0;
            occ_q       <= '0;
            fill_left_q <= '0;
            eod_q       <= 1'b0;
        end else begin
            eod_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (launch) begin
                        if (launch_cnt == '0) begin
                            eod_q <= 1'b1;
                        end else begin
                            state_q     <= ST_FILL;
                            rem_q       <= launch_cnt;
                            occ_q       <= '0;
                            fill_left_q <= cap_or_rem(launch_cnt, launch_cap);
                        end
                    end
                end
                ST_FILL: begin
                    if (xfer_done) begin
                        occ_q       <= occ_q + cur_size;
                        fill_left_q <= fill_left_q - cur_size;
                        if (cur_size == fill_left_q) state_q <= ST_DRAIN;
                    end
                end
                ST_DRAIN: begin
                    if (xfer_done) begin
                        occ_q <= occ_q - cur_size;
                        rem_q <= rem_after;
                        if (cur_size == occ_q) begin
                            if (rem_after == '0) begin
                                state_q <= ST_IDLE;
                                eod_q   <= 1'b1;
                            end else begin
                                state_q     <= ST_FILL;
                                fill_left_q <= cap_or_rem(rem_after, cap);
                            end
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_valid  = (state_q == ST_FILL) || (state_q == ST_DRAIN);
    assign req.write  = (state_q == ST_DRAIN);
    assign req.periph = (state_q == ST_DRAIN) ? plan.dst_periph :
                        (state_q == ST_FILL)  ? plan.src_periph : 1'b0;
    assign req.size   = cur_size;
    assign eod        = eod_q;
    assign busy       = req_valid;
endmodule

// File: rtl/dma_stg_seq.sv
module dma_stg_seq
    import dma_stg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [1:0]       mode,
    input  logic [SZ_W-1:0]  buf_cap,
    input  logic [SZ_W-1:0]  port_size,
    input  logic [SZ_W-1:0]  mm_dst_size,
    input  logic [CNT_W-1:0] byte_count,
    input  logic             xfer_done,
    output logic             req_valid,
    output logic             req_write,
    output logic             req_periph,
    output logic [SZ_W-1:0]  req_size,
    output logic             eod,
    output logic             busy
);
    stg_cfg_t   cfg_q;
    side_plan_t plan;
    xfer_req_t  req;
    logic       launch;
    logic       busy_w;

    assign launch = start && !busy_w && (xfer_mode_e'(mode) != XM_RSVD) && (buf_cap != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (launch) begin
            cfg_q.mode <= xfer_mode_e'(mode);
            cfg_q.cap  <= buf_cap;
            cfg_q.port <= port_size;
            cfg_q.dst  <= mm_dst_size;
        end
    end

    stg_side_plan u_plan (
        .cfg  (cfg_q),
        .plan (plan)
    );

    stg_fill_drain_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .launch     (launch),
        .launch_cnt (byte_count),
        .launch_cap (buf_cap),
        .cap        (cfg_q.cap),
        .plan       (plan),
        .xfer_done  (xfer_done),
        .req_valid  (req_valid),
        .req        (req),
        .eod        (eod),
        .busy       (busy_w)
    );

    assign busy       = busy_w;
    assign req_write  = req.write;
    assign req_periph = req.periph;
    assign req_size   = req.size;
endmodule

// File: rtl/dma_stg_seq_chk.sv
module dma_stg_seq_chk
    import dma_stg_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic [SZ_W-1:0] buf_cap,
    input logic            xfer_done,
    input logic            req_valid,
    input logic            req_write,
    input logic            req_periph,
    input logic [SZ_W-1:0] req_size,
    input logic            eod,
    input logic            busy
);
    logic [SZ_W:0]   sh_occ;
    logic [SZ_W-1:0] cap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_occ <= '0;
            cap_q  <= '0;
        end else begin
            if (start && !busy) cap_q <= buf_cap;
            if (req_valid && xfer_done) begin
                if (req_write) sh_occ <= sh_occ - (SZ_W+1)'(req_size);
                else           sh_occ <= sh_occ + (SZ_W+1)'(req_size);
            end
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!req_valid && !eod && !busy));

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> sh_occ <= (SZ_W+1)'(cap_q));

    p_drain_has_data_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write) |-> (SZ_W+1)'(req_size) <= sh_occ);

    p_fill_after_empty_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && $past(req_valid && req_write)) |-> sh_occ == '0);

    p_size_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> req_size != '0);

    p_hold_until_done_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !xfer_done) |=>
            (req_valid && $stable(req_size) && $stable(req_write) && $stable(req_periph)));

    p_eod_single_r10: assert property (@(posedge clk) disable iff (rst)
        eod |=> !eod);

    p_eod_idle_empty_r10: assert property (@(posedge clk) disable iff (rst)
        eod |-> (!busy && sh_occ == '0));

    p_busy_start_ignored_r12: assert property (@(posedge clk) disable iff (rst)
        (start && busy && !xfer_done) |=> busy);
endmodule

bind dma_stg_seq dma_stg_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .buf_cap    (buf_cap),
    .xfer_done  (xfer_done),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_periph (req_periph),
    .req_size   (req_size),
    .eod        (eod),
    .busy       (busy)
);

// File: tb/test_dma_stg_seq.sv
module test_dma_stg_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [7:0]  buf_cap = 8'd0;
    logic [7:0]  port_size = 8'd0;
    logic [7:0]  mm_dst_size = 8'd0;
    logic [15:0] byte_count = 16'd0;
    logic        xfer_done = 1'b0;
    logic        req_valid, req_write, req_periph, eod, busy;
    logic [7:0]  req_size;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    dma_stg_seq i_dma_stg_seq (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .buf_cap(buf_cap),
        .port_size(port_size), .mm_dst_size(mm_dst_size), .byte_count(byte_count),
        .xfer_done(xfer_done), .req_valid(req_valid), .req_write(req_write),
        .req_periph(req_periph), .req_size(req_size), .eod(eod), .busy(busy)
    );

    typedef struct packed {
        logic [1:0]  md;
        logic [7:0]  cap;
        logic [7:0]  port;
        logic [7:0]  dst;
        logic [15:0] cnt;
        logic [7:0]  exp_n;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t TBL [NV] = '{
        '{2'b01, 8'd16, 8'd4,  8'd0,  16'd16, 8'd5},
        '{2'b01, 8'd16, 8'd0,  8'd0,  16'd40, 8'd6},
        '{2'b10, 8'd8,  8'd2,  8'd0,  16'd8,  8'd5},
        '{2'b10, 8'd8,  8'd4,  8'd0,  16'd10, 8'd5},
        '{2'b00, 8'd16, 8'd0,  8'd4,  16'd16, 8'd5},
        '{2'b00, 8'd8,  8'd0,  8'd0,  16'd20, 8'd6},
        '{2'b01, 8'd12, 8'd5,  8'd0,  16'd7,  8'd3},
        '{2'b00, 8'd8,  8'd0,  8'd20, 16'd8,  8'd2},
        '{2'b10, 8'd16, 8'd40, 8'd0,  16'd16, 8'd2}
    };

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    task automatic run_case(input logic [1:0] md, input int cap, input int port,
                            input int dst, input int cnt, input int exp_n,
                            input int dly, input bit poke, input string rq);
        int pc   = (port == 0 || port > 32) ? 32 : port;
        int mdst = (dst == 0 || dst > cap) ? cap : dst;
        int ssz  = (md == 2'b10) ? pc : cap;
        int dsz  = (md == 2'b01) ? pc : (md == 2'b10) ? cap : mdst;
        bit sp   = (md == 2'b10);
        bit dp   = (md == 2'b01);
        int rem  = cnt;
        int occ  = 0;
        int fl   = imin(cap, cnt);
        int n    = 0;
        int tot  = 0;
        bit drn  = 1'b0;
        bit fin  = 1'b0;
        @(negedge clk);
        mode = md; buf_cap = 8'(cap); port_size = 8'(port);
        mm_dst_size = 8'(dst); byte_count = 16'(cnt); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R11: scramble the configuration inputs during the job
        mode = ~md; buf_cap = 8'd3; port_size = 8'd1; mm_dst_size = 8'd1; byte_count = 16'd99;
        if (cnt == 0) begin
            chk(eod === 1'b1, "R10 zero-count eod", int'(eod), 1);
            chk(req_valid === 1'b0, "R10 zero-count no request", int'(req_valid), 0);
            return;
        end
        while (!fin) begin
            int esz = drn ? imin(dsz, occ) : imin(ssz, fl);
            bit eper = drn ? dp : sp;
            for (int d = 0; d < dly; d++) begin
                if (poke && n == 0 && d == 0) begin
                    start = 1'b1; mode = 2'b10; buf_cap = 8'd2; byte_count = 16'd2;
                end
                @(negedge clk);
                start = 1'b0;
                chk(req_valid === 1'b1, "R9 waits for done", int'(req_valid), 1);
                chk(int'(req_size) == esz, poke ? "R12 busy start ignored" : "R8 size held",
                    int'(req_size), esz);
            end
            chk(req_valid === 1'b1, {rq, " request valid"}, int'(req_valid), 1);
            chk(req_write === drn, {rq, " direction"}, int'(req_write), int'(drn));
            chk(int'(req_size) == esz, {rq, " size"}, int'(req_size), esz);
            chk(req_periph === eper, {rq, " peripheral flag"}, int'(req_periph), int'(eper));
            n++;
            xfer_done = 1'b1;
            @(negedge clk);
            xfer_done = 1'b0;
            if (!drn) begin
                occ += esz; fl -= esz;
                if (fl == 0) drn = 1'b1;
            end else begin
                occ -= esz; rem -= esz; tot += esz;
                if (occ == 0) begin
                    if (rem == 0) fin = 1'b1;
                    else begin drn = 1'b0; fl = imin(cap, rem); end
                end
            end
        end
        chk(eod === 1'b1, "R10 eod after final write", int'(eod), 1);
        chk(busy === 1'b0, "R10 idle with eod", int'(busy), 0);
        chk(n == exp_n, {rq, " transfer count"}, n, exp_n);
        chk(tot == cnt, "R7 bytes written total", tot, cnt);
        @(negedge clk);
        chk(eod === 1'b0, "R10 eod one cycle", int'(eod), 0);
    endtask

    initial begin
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(req_valid === 1'b0 && eod === 1'b0 && busy === 1'b0, "R1 in reset",
            int'({req_valid, eod, busy}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(req_valid === 1'b0 && eod === 1'b0 && busy === 1'b0, "R1 after reset",
            int'({req_valid, eod, busy}), 0);

        for (int i = 0; i < NV; i++) begin
            string rq = (TBL[i].md == 2'b01) ? "R3" : (TBL[i].md == 2'b10) ? "R4" : "R5";
            run_case(TBL[i].md, int'(TBL[i].cap), int'(TBL[i].port), int'(TBL[i].dst),
                     int'(TBL[i].cnt), int'(TBL[i].exp_n), i % 3, 1'b0, rq);
        end

        // R2: reserved mode start ignored
        @(negedge clk);
        mode = 2'b11; buf_cap = 8'd8; byte_count = 16'd8; start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(req_valid === 1'b0 && busy === 1'b0, "R2 reserved mode",
            int'({req_valid, busy}), 0);
        // R2: zero capacity start ignored
        mode = 2'b01; buf_cap = 8'd0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(req_valid === 1'b0 && eod === 1'b0, "R2 zero capacity",
            int'({req_valid, eod}), 0);

        // R10: zero byte count
        run_case(2'b01, 8, 4, 0, 0, 0, 0, 1'b0, "R10");

        // R12: start while busy ignored, R7 shortened last piece
        run_case(2'b01, 8, 4, 0, 8, 3, 2, 1'b1, "R3");
        run_case(2'b10, 8, 3, 0, 7, 4, 0, 1'b0, "R7");

        // R12: start in the eod cycle is accepted
        @(negedge clk);
        mode = 2'b01; buf_cap = 8'd8; port_size = 8'd8; byte_count = 16'd8; start = 1'b1;
        @(negedge clk); start = 1'b0;
        xfer_done = 1'b1;
        @(negedge clk);
        chk(req_write === 1'b1 && int'(req_size) == 8, "R3 single drain write",
            int'(req_size), 8);
        @(negedge clk);
        xfer_done = 1'b0;
        chk(eod === 1'b1, "R10 eod before restart", int'(eod), 1);
        mode = 2'b10; buf_cap = 8'd4; port_size = 8'd4; byte_count = 16'd4; start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(req_valid === 1'b1, "R12 start in eod cycle", int'(req_valid), 1);
        chk(req_write === 1'b0 && req_periph === 1'b1 && int'(req_size) == 4,
            "R12 new job first fill", int'(req_size), 4);
        xfer_done = 1'b1;
        @(negedge clk);
        @(negedge clk);
        xfer_done = 1'b0;
        chk(eod === 1'b1, "R10 chained job end", int'(eod), 1);

        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule